// File: doc/BRIEF.md
# Two-Tier Rotating Bus Arbiter

This block decides which of five initiators on a downstream shared bus may drive the next transaction. Four of them are external request/grant pairs. The fifth, at index 4, is the bridge's own internal initiator. Each requester is placed in either a high-priority tier or a low-priority tier. The high tier is served round-robin. The low tier as a whole holds one seat in that rotation and rotates among its own members whenever that seat comes up. When the promotion feature is on, a master that has been retried or has a delayed transaction pending is lifted into the high tier.

A grant is issued only on an idle bus while no grant is outstanding. It is then held until one of three things happens: the owner's transaction ends, the owner withdraws its request before starting, or the owner lets 16 clocks pass without driving FRAME. A timeout removes the grant and sets a sticky per-requester flag, which software clears by writing ones. If enabled, a timeout also produces a one-cycle error strobe.

Top module: `tier_rr_arbiter`

## Requirements
- R1: While reset is held, `gnt_o`, `tmo_sts_o` and `tmo_err_o` are all zero.
- R2: At most one bit of `gnt_o` is set in any cycle.
- R3: A requester whose `mask_i` bit is 1 is never granted, and when every requesting line is masked no grant is issued.
- R4: A grant appears only in the cycle after one in which `bus_idle_i` was 1 and no grant was held. Once set, `gnt_o` keeps the same value until it returns to zero.
- R5: High-tier requesters (`tier_hi_i` bit = 1) are served in ascending index order, starting after the last high-tier winner. The low-tier seat occupies the position after index 4, and after reset the search begins at index 0.
- R6: The low-tier seat is taken only if some eligible low-tier requester exists. It grants one low-tier requester per turn, rotating in ascending index order after the last low-tier winner. After reset the low-tier search starts at index 0.
- R7: With `promote_en_i` = 1, a requester whose `retried_i` bit is 1 is arbitrated as high tier. With `promote_en_i` = 0, `retried_i` has no effect.
- R8: If the owner holds its grant for 16 clocks without `frame_i`, the grant is removed at the 16th clock edge after it was given.
- R9: A timeout sets the `tmo_sts_o` bit of the owner. Each bit stays set until a 1 is written on the same bit of `tmo_clr_i`. A timeout that happens in the same cycle as a clear leaves the bit set.
- R10: `tmo_err_o` is high for exactly the one cycle after a timeout, and only when `tmo_err_en_i` was 1 at that timeout.
- R11: After the owner raises `frame_i`, its grant holds until a cycle with `bus_idle_i` = 1 and `frame_i` = 0, and then drops. An owner that withdraws its request, or is masked, before raising `frame_i` loses its grant at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 5 | Request lines; bit 4 is the internal initiator |
| frame_i | input | 1 | FRAME observed asserted on the bus |
| bus_idle_i | input | 1 | Bus is idle (no transaction in progress) |
| tier_hi_i | input | 5 | Per-requester tier: 1 = high, 0 = low |
| mask_i | input | 5 | Per-requester mask: 1 = never grant |
| promote_en_i | input | 1 | Enables promotion of retried masters |
| retried_i | input | 5 | Requester was retried or has a pending delayed transaction |
| tmo_clr_i | input | 5 | Write-one-to-clear strobes for the timeout flags |
| tmo_err_en_i | input | 1 | Enables the error strobe on timeout |
| gnt_o | output | 5 | One-hot grant |
| tmo_sts_o | output | 5 | Sticky timeout flags |
| tmo_err_o | output | 1 | One-cycle error strobe on an enabled timeout |

## Verification
The hardest state to reach from the ports is a low-tier seat arriving while the high ring and the low ring pointers sit at unrelated positions. In that state a promoted master competes with a masked one, and the grant order depends on rotation history, not on the current inputs alone. The stimulus sweeps every tier assignment against every request pattern, with mask, retry and promotion values derived from the loop indices. It performs three full transactions per combination without resetting in between, so both pointers carry history from one combination to the next. The timeout path is driven separately: a clear is placed on the exact edge of the timeout to show that setting wins.

// File: rtl/tra_pkg.sv
package tra_pkg;

  localparam int RING_MAX = 16;
  localparam int RING_IW  = 4;

  // Why the current grant is being withdrawn
  typedef enum logic [1:0] {
    DROP_NONE = 2'd0,
    DROP_GONE = 2'd1,
    DROP_TMO  = 2'd2,
    DROP_DONE = 2'd3
  } drop_e;

  // First set candidate strictly after position 'last', wrapping at 'width'.
  // Returns -1 when no candidate is set.
  function automatic int ring_next(input logic [RING_MAX-1:0] cand,
                                   input int last, input int width);
    int pos;
    ring_next = -1;
    for (int k = RING_MAX; k >= 1; k--) begin
      if (k <= width) begin
        pos = last + k;
        if (pos >= width) pos = pos - width;
        if (pos >= width) pos = pos - width;
        if (cand[pos[RING_IW-1:0]]) ring_next = pos;
      end
    end
  endfunction

endpackage

// File: rtl/tra_rr_pick.sv
module tra_rr_pick #(
  parameter int W  = 5,
  parameter int IW = 3
) (
  input  logic [W-1:0]  cand,
  input  logic [IW-1:0] last,
  output logic [IW-1:0] idx,
  output logic          valid
);
  import tra_pkg::*;

  int found;

  always_comb begin
    found = ring_next(RING_MAX'(cand), int'(last), W);
    valid = (found >= 0);
    idx   = valid ? IW'(found) : '0;
  end

endmodule

// File: rtl/tra_watch.sv
module tra_watch #(
  parameter int N   = 5,
  parameter int TMO = 16,
  parameter int IW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant_go,
  input  logic          waiting,
  input  logic [IW-1:0] own,
  input  logic [N-1:0]  clr,
  input  logic          err_en,
  output logic          fire,
  output logic [N-1:0]  sts,
  output logic          err
);
  localparam int CW = (TMO > 2) ? $clog2(TMO) : 1;

  logic [CW-1:0] cnt_q;
  logic [N-1:0]  set_vec;

  assign fire    = waiting && (cnt_q == CW'(TMO - 1));
  assign set_vec = fire ? (N'(1) << own) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sts   <= '0;
      err   <= 1'b0;
    end else begin
      if (grant_go)               cnt_q <= '0;
      else if (waiting && !fire)  cnt_q <= cnt_q + 1'b1;
      sts <= (sts & ~clr) | set_vec;
      err <= fire && err_en;
    end
  end

endmodule

// File: rtl/tier_rr_arbiter.sv
module tier_rr_arbiter #(
  parameter int N           = 5,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic         frame_i,
  input  logic         bus_idle_i,
  input  logic [N-1:0] tier_hi_i,
  input  logic [N-1:0] mask_i,
  input  logic         promote_en_i,
  input  logic [N-1:0] retried_i,
  input  logic [N-1:0] tmo_clr_i,
  input  logic         tmo_err_en_i,
  output logic [N-1:0] gnt_o,
  output logic [N-1:0] tmo_sts_o,
  output logic         tmo_err_o
);
  import tra_pkg::*;

  localparam int IW     = $clog2(N + 1);
  localparam int HRING  = N + 1;

  logic [N-1:0]  gnt_q;
  logic [IW-1:0] own_q, ptr_h_q, ptr_l_q;
  logic          started_q;

  // Named internal events (observed by the checker)
  logic [N-1:0]  elig, hi_eff, lo_cand;
  logic [N:0]    cand_h;
  logic [IW-1:0] idx_h, idx_l, win_idx;
  logic          v_h, v_l, win_is_lo;
  logic          busy, owner_live, waiting, grant_go, start_evt, tmo_fire;
  drop_e         drop_cause;

  assign elig    = req_i & ~mask_i;
  assign hi_eff  = tier_hi_i | ({N{promote_en_i}} & retried_i);
  assign lo_cand = elig & ~hi_eff;
  assign cand_h  = {|lo_cand, elig & hi_eff};

  tra_rr_pick #(.W(HRING), .IW(IW)) pick_hi_i (
    .cand (cand_h),
    .last (ptr_h_q),
    .idx  (idx_h),
    .valid(v_h)
  );

  tra_rr_pick #(.W(N), .IW(IW)) pick_lo_i (
    .cand (lo_cand),
    .last (ptr_l_q),
    .idx  (idx_l),
    .valid(v_l)
  );

  assign win_is_lo  = v_h && (idx_h == IW'(N)) && v_l;
  assign win_idx    = win_is_lo ? idx_l : idx_h;

  assign busy       = |gnt_q;
  assign owner_live = |(gnt_q & elig);
  assign grant_go   = !busy && bus_idle_i && v_h;
  assign start_evt  = busy && !started_q && frame_i;
  assign waiting    = busy && !started_q && !frame_i && owner_live;

  tra_watch #(.N(N), .TMO(TIMEOUT_CYC), .IW(IW)) watch_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .grant_go(grant_go),
    .waiting (waiting),
    .own     (own_q),
    .clr     (tmo_clr_i),
    .err_en  (tmo_err_en_i),
    .fire    (tmo_fire),
    .sts     (tmo_sts_o),
    .err     (tmo_err_o)
  );

  always_comb begin
    drop_cause = DROP_NONE;
    if (busy) begin
      if (!started_q && !frame_i && !owner_live)  drop_cause = DROP_GONE;
      else if (tmo_fire)                          drop_cause = DROP_TMO;
      else if (started_q && bus_idle_i && !frame_i) drop_cause = DROP_DONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q     <= '0;
      own_q     <= '0;
      started_q <= 1'b0;
      ptr_h_q   <= IW'(N);
      ptr_l_q   <= IW'(N - 1);
    end else if (grant_go) begin
      gnt_q     <= N'(1) << win_idx;
      own_q     <= win_idx;
      started_q <= 1'b0;
      ptr_h_q   <= idx_h;
      if (win_is_lo) ptr_l_q <= idx_l;
    end else if (drop_cause != DROP_NONE) begin
      gnt_q     <= '0;
      started_q <= 1'b0;
    end else if (start_evt) begin
      started_q <= 1'b1;
    end
  end

  assign gnt_o = gnt_q;

endmodule

// File: rtl/tier_rr_arbiter_chk.sv
module tier_rr_arbiter_chk #(
  parameter int N = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] mask_i,
  input logic         bus_idle_i,
  input logic [N-1:0] tmo_clr_i,
  input logic         tmo_err_en_i,
  input logic [N-1:0] gnt_o,
  input logic [N-1:0] tmo_sts_o,
  input logic         tmo_err_o,
  input logic         tmo_fire
);

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  // R3
  mask_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt_o) && !$past(|gnt_o)) |-> ((gnt_o & $past(mask_i)) == '0));

  // R4
  grant_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt_o) && !$past(|gnt_o)) |-> $past(bus_idle_i));

  // R4
  grant_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt_o) && $past(|gnt_o)) |-> (gnt_o == $past(gnt_o)));

  // R8
  timeout_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> (gnt_o == '0));

  // R9
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(tmo_sts_o) & ~tmo_sts_o & ~$past(tmo_clr_i)) == '0));

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err_o |-> ($past(tmo_fire) && $past(tmo_err_en_i)));

  // R10
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err_o |=> !tmo_err_o);

endmodule

bind tier_rr_arbiter tier_rr_arbiter_chk #(.N(N)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .mask_i      (mask_i),
  .bus_idle_i  (bus_idle_i),
  .tmo_clr_i   (tmo_clr_i),
  .tmo_err_en_i(tmo_err_en_i),
  .gnt_o       (gnt_o),
  .tmo_sts_o   (tmo_sts_o),
  .tmo_err_o   (tmo_err_o),
  .tmo_fire    (tmo_fire)
);

// File: tb/tier_rr_arbiter_tb_top.sv
module tier_rr_arbiter_tb_top;
  localparam int N = 5;
  localparam logic [N-1:0] ONE = 5'd1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic [N-1:0] req_i, tier_hi_i, mask_i, retried_i, tmo_clr_i;
  logic         frame_i, bus_idle_i, promote_en_i, tmo_err_en_i;
  logic [N-1:0] gnt_o, tmo_sts_o;
  logic         tmo_err_o;

  int checks = 0;
  int errors = 0;
  int hp = N;       // last high-ring winner position (N = low seat)
  int lp = N - 1;   // last low-tier winner

  tier_rr_arbiter #(.N(N), .TIMEOUT_CYC(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .frame_i(frame_i),
    .bus_idle_i(bus_idle_i), .tier_hi_i(tier_hi_i), .mask_i(mask_i),
    .promote_en_i(promote_en_i), .retried_i(retried_i),
    .tmo_clr_i(tmo_clr_i), .tmo_err_en_i(tmo_err_en_i),
    .gnt_o(gnt_o), .tmo_sts_o(tmo_sts_o), .tmo_err_o(tmo_err_o)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Rotation restated: walk six seats after hp; seat N hands over to the low ring.
  task automatic model_pick(input logic [N-1:0] el, input logic [N-1:0] hi,
                            output int w, output bit is_lo);
    logic [N-1:0] hs, ls;
    hs = el & hi;
    ls = el & ~hi;
    w = -1;
    is_lo = 1'b0;
    for (int k = 1; k <= N + 1; k++) begin
      int p;
      p = (hp + k) % (N + 1);
      if (w < 0) begin
        if (p < N && hs[p]) w = p;
        else if (p == N && ls != '0) begin
          is_lo = 1'b1;
          for (int j = 1; j <= N; j++) begin
            int q;
            q = (lp + j) % N;
            if (w < 0 && ls[q]) w = q;
          end
        end
      end
    end
  endtask

  task automatic serve(input int w, input string tag);
    @(negedge clk);
    chk(gnt_o == (ONE << w), tag, 32'(gnt_o), 32'(ONE << w));
    frame_i = 1'b1; bus_idle_i = 1'b0;
    @(negedge clk);
    chk(gnt_o == (ONE << w), "R11 grant held during frame", 32'(gnt_o), 32'(ONE << w));
    frame_i = 1'b0; bus_idle_i = 1'b1;
    @(negedge clk);
    chk(gnt_o == '0, "R11 release at transaction end", 32'(gnt_o), 32'h0);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog requirement=all actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_i = '0; tier_hi_i = '0; mask_i = '0; retried_i = '0; tmo_clr_i = '0;
    frame_i = 1'b0; bus_idle_i = 1'b1; promote_en_i = 1'b0; tmo_err_en_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(gnt_o == '0, "R1 grant in reset", 32'(gnt_o), 32'h0);
    chk(tmo_sts_o == '0, "R1 status in reset", 32'(tmo_sts_o), 32'h0);
    chk(tmo_err_o == 1'b0, "R1 error in reset", 32'(tmo_err_o), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep: every tier map against every request pattern
    for (int cfg = 0; cfg < 32; cfg++) begin
      for (int r = 1; r < 32; r++) begin
        logic [N-1:0] el, hi;
        bit pe;
        tier_hi_i    = N'(cfg);
        req_i        = N'(r);
        mask_i       = N'(cfg ^ (r << 1)) & 5'b01001;
        retried_i    = N'(r * 5 + cfg);
        pe           = ((cfg >> 1) & 1) != (r & 1);
        promote_en_i = pe;
        el = req_i & ~mask_i;
        hi = tier_hi_i | (pe ? retried_i : '0);
        for (int t = 0; t < 3; t++) begin
          int w;
          bit lo;
          model_pick(el, hi, w, lo);
          if (w < 0) begin
            repeat (2) @(negedge clk);
            chk(gnt_o == '0, "R3 all requests masked", 32'(gnt_o), 32'h0);
          end else begin
            if (lo)
              serve(w, "R6 low tier turn");
            else if (pe && retried_i[w] && !tier_hi_i[w])
              serve(w, "R7 promoted master turn");
            else
              serve(w, "R5 high tier turn");
            if (lo) begin hp = N; lp = w; end
            else hp = w;
          end
        end
      end
    end

    mask_i = '0; retried_i = '0; promote_en_i = 1'b0; tier_hi_i = '0;
    req_i = '0;
    @(negedge clk);

    // R3: sole requester masked
    req_i = 5'b00010; mask_i = 5'b00010;
    repeat (3) @(negedge clk);
    chk(gnt_o == '0, "R3 masked sole requester", 32'(gnt_o), 32'h0);
    req_i = '0; mask_i = '0;

    // R4: no grant while bus busy
    bus_idle_i = 1'b0; req_i = 5'b11111;
    repeat (3) @(negedge clk);
    chk(gnt_o == '0, "R4 no grant on busy bus", 32'(gnt_o), 32'h0);
    bus_idle_i = 1'b1;
    @(negedge clk);
    chk($onehot(gnt_o), "R4 grant once idle", 32'(gnt_o), 32'h1);
    frame_i = 1'b1; bus_idle_i = 1'b0;
    @(negedge clk);
    frame_i = 1'b0; bus_idle_i = 1'b1;
    @(negedge clk);
    req_i = '0;
    @(negedge clk);

    // R11: owner withdraws before frame
    req_i = 5'b01000;
    @(negedge clk);
    chk(gnt_o == 5'b01000, "R11 grant to sole requester", 32'(gnt_o), 32'h8);
    req_i = '0;
    @(negedge clk);
    chk(gnt_o == '0, "R11 withdrawn request drops grant", 32'(gnt_o), 32'h0);

    // R8/R9/R10: timeout with error enabled, clear on the same edge
    tmo_err_en_i = 1'b1; req_i = 5'b00100;
    @(negedge clk);
    chk(gnt_o == 5'b00100, "R8 grant before timeout", 32'(gnt_o), 32'h4);
    repeat (15) @(negedge clk);
    chk(gnt_o == 5'b00100, "R8 grant held for 16 clocks", 32'(gnt_o), 32'h4);
    chk(tmo_sts_o == '0, "R8 no flag before timeout", 32'(tmo_sts_o), 32'h0);
    tmo_clr_i = 5'b00100;
    @(negedge clk);
    chk(gnt_o == '0, "R8 grant removed at timeout", 32'(gnt_o), 32'h0);
    chk(tmo_sts_o == 5'b00100, "R9 set wins over clear", 32'(tmo_sts_o), 32'h4);
    chk(tmo_err_o == 1'b1, "R10 error strobe", 32'(tmo_err_o), 32'h1);
    tmo_clr_i = '0; req_i = '0;
    @(negedge clk);
    chk(tmo_err_o == 1'b0, "R10 strobe lasts one cycle", 32'(tmo_err_o), 32'h0);
    chk(tmo_sts_o == 5'b00100, "R9 flag sticky", 32'(tmo_sts_o), 32'h4);
    tmo_clr_i = 5'b00100;
    @(negedge clk);
    chk(tmo_sts_o == '0, "R9 write-one clears", 32'(tmo_sts_o), 32'h0);
    tmo_clr_i = '0;

    // Timeout with error disabled
    tmo_err_en_i = 1'b0; req_i = 5'b00001;
    @(negedge clk);
    chk(gnt_o == 5'b00001, "R8 second grant", 32'(gnt_o), 32'h1);
    repeat (16) @(negedge clk);
    chk(gnt_o == '0, "R8 second timeout drop", 32'(gnt_o), 32'h0);
    chk(tmo_sts_o == 5'b00001, "R9 flag for requester 0", 32'(tmo_sts_o), 32'h1);
    chk(tmo_err_o == 1'b0, "R10 strobe disabled", 32'(tmo_err_o), 32'h0);
    req_i = '0; tmo_clr_i = 5'b11111;
    @(negedge clk);
    chk(tmo_sts_o == '0, "R9 clear all", 32'(tmo_sts_o), 32'h0);
    tmo_clr_i = '0;
    @(negedge clk);

    summary();
    $finish;
  end

endmodule